// File: doc/BRIEF.md
# Receive FIFO Flow-Control Trigger

This block watches how full a 128-entry receive FIFO is and tells the far end when to pause and when to carry on sending. Two thresholds, one for pausing and one for resuming, are packed as 4-bit fields into a single 8-bit configuration register. Each field is multiplied by 8 to give a FIFO level. Because the thresholds are separate, the block has hysteresis: once paused, it stays paused until the level has drained down to the resume point.

Two flow-control styles are available. In hardware mode the block raises a request-to-send line to pause the sender and lowers it to resume. In software mode it asks the UART transmitter to insert an XOFF or XON character. The request is held as a single pending character until the transmitter acknowledges it. If both modes are off, the block stays quiet. The FIFO storage, the transmit datapath and gating of the transmitter by clear-to-send are handled elsewhere.

Top module: `rx_flow_trigger`

## Requirements
- R1: After reset, `rts_o` and `xchar_req` are low and the configuration register holds 0. With the register at 0, hardware mode at FIFO level 0 halts on the second clock after the mode is enabled and resumes on the third.
- R2: The halt threshold is 8 × `cfg_wdata[3:0]`. A halt event occurs at a clock edge when flow control is active, the block is not halted and `fifo_level` is at least that threshold.
- R3: The resume threshold is 8 × `cfg_wdata[7:4]`. A resume event occurs at a clock edge when the block is halted and `fifo_level` is at most that threshold.
- R4: While the level lies strictly between the two thresholds, the halted state does not change.
- R5: In hardware mode, `rts_o` is high exactly while the block is halted, updating one clock after the level is sampled. In any other mode `rts_o` is low.
- R6: In software mode a halt event sets `xchar_req` with `xchar_code` = 0x13 (XOFF) on the next clock.
- R7: In software mode a resume event sets `xchar_req` with `xchar_code` = 0x11 (XON) on the next clock.
- R8: A pending request and its code stay unchanged until `xchar_ack` is sampled high while `xchar_req` is high. That acknowledgement clears the request on the same edge.
- R9: A new event replaces a pending, unacknowledged request with the new character.
- R10: With both enables low, `rts_o` stays low and no character is requested. With both enables high, hardware mode takes priority.
- R11: A change of effective mode clears the halted state and drops any pending request at that edge. No event is evaluated at that edge.
- R12: A configuration write with `cfg_we` takes effect for events from the clock after the write edge. The write edge itself still uses the old thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the threshold register |
| cfg_wdata | input | 8 | Threshold register data: resume field in [7:4], halt field in [3:0] |
| hw_flow_en | input | 1 | Enable request-to-send flow control |
| sw_flow_en | input | 1 | Enable XON/XOFF character flow control |
| fifo_level | input | 8 | Current receive FIFO fill level, 0 to 128 |
| rts_o | output | 1 | Request-to-send line; high asks the far end to pause |
| xchar_req | output | 1 | Pending request for the transmitter to insert a flow character |
| xchar_code | output | 8 | Character to insert, XOFF or XON |
| xchar_ack | input | 1 | Transmitter has taken the pending character |

## Verification
The assertions assume that `fifo_level` never exceeds the FIFO depth. They also assume that `xchar_ack` is only a qualifier, so an acknowledgement arriving while nothing is pending has no effect. The enables are treated as quasi-static, so a mode is always seen as stable or changed at a clock edge. The stimulus drives every input at the falling edge and keeps levels between 0 and 128. It raises acknowledgements in an irregular pattern, including cycles with nothing pending. Each mode change is followed by full level ramps, so every threshold pair is reached from a settled state.

// File: rtl/flow_ctl_pkg.sv
package flow_ctl_pkg;

   typedef enum logic [1:0] {
      FC_OFF = 2'd0,
      FC_HW  = 2'd1,
      FC_SW  = 2'd2
   } fc_mode_e;

   localparam logic [7:0] FC_XOFF_DEFAULT = 8'h13;
   localparam logic [7:0] FC_XON_DEFAULT  = 8'h11;

endpackage

// File: rtl/flow_thr_reg.sv
module flow_thr_reg #(
   parameter int FIELD_W  = 4,
   parameter int SCALE_SH = 3,
   parameter int LVL_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2*FIELD_W-1:0] wr_data,
   output logic [LVL_W-1:0]     halt_thr,
   output logic [LVL_W-1:0]     resume_thr
);

   localparam int CFG_W   = 2 * FIELD_W;
   localparam int N_FIELD = 2;

   logic [CFG_W-1:0]              cfg_q;
   logic [N_FIELD-1:0][LVL_W-1:0] thr_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (wr_en)
         cfg_q <= wr_data;
   end

   // field 0 is the halt level, field 1 the resume level; both scaled alike
   for (genvar f = 0; f < N_FIELD; f++) begin : g_field
      assign thr_w[f] = LVL_W'(cfg_q[f*FIELD_W +: FIELD_W]) << SCALE_SH;
   end

   assign halt_thr   = thr_w[0];
   assign resume_thr = thr_w[1];

   initial begin
      assert (FIELD_W + SCALE_SH <= LVL_W)
         else $error("scaled threshold does not fit the level width");
   end

   assert_cfg_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (halt_thr == (LVL_W'($past(wr_data[FIELD_W-1:0])) << SCALE_SH)));

endmodule

// File: rtl/flow_mode_state.sv
module flow_mode_state
   import flow_ctl_pkg::*;
#(
   parameter int LVL_W       = 8,
   parameter bit HW_PRIORITY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hw_en,
   input  logic             sw_en,
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] halt_thr,
   input  logic [LVL_W-1:0] resume_thr,
   output fc_mode_e         mode_q,
   output logic             mode_chg,
   output logic             halted_q,
   output logic             ev_halt,
   output logic             ev_resume
);

   fc_mode_e mode_now;

   if (HW_PRIORITY) begin : g_hw_first
      always_comb begin
         if (hw_en)      mode_now = FC_HW;
         else if (sw_en) mode_now = FC_SW;
         else            mode_now = FC_OFF;
      end
   end else begin : g_sw_first
      always_comb begin
         if (sw_en)      mode_now = FC_SW;
         else if (hw_en) mode_now = FC_HW;
         else            mode_now = FC_OFF;
      end
   end

   assign mode_chg  = (mode_now != mode_q);
   assign ev_halt   = !mode_chg && (mode_q != FC_OFF) && !halted_q && (level >= halt_thr);
   assign ev_resume = !mode_chg && halted_q && (level <= resume_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= FC_OFF;
         halted_q <= 1'b0;
      end else begin
         mode_q <= mode_now;
         if (mode_chg)
            halted_q <= 1'b0;
         else if (ev_halt)
            halted_q <= 1'b1;
         else if (ev_resume)
            halted_q <= 1'b0;
      end
   end

   assert_halt_reach_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_en || sw_en) && $stable(hw_en) && $stable(sw_en) && !halted_q
      && (level >= halt_thr) && (mode_q != FC_OFF) |=> halted_q);

   assert_resume_reach_R3: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q && (mode_now == mode_q) && (level <= resume_thr) |=> !halted_q);

   assert_hysteresis_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_now == mode_q) && (level > resume_thr) && (level < halt_thr)
      |=> $stable(halted_q));

   assert_mode_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_now != mode_q) |=> !halted_q);

endmodule

// File: rtl/flow_char_queue.sv
module flow_char_queue #(
   parameter int               CHAR_W    = 8,
   parameter logic [CHAR_W-1:0] XOFF_CHAR = 8'h13,
   parameter logic [CHAR_W-1:0] XON_CHAR  = 8'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              ev_xoff,
   input  logic              ev_xon,
   input  logic              ack,
   output logic              req_q,
   output logic [CHAR_W-1:0] code_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         code_q <= '0;
      end else if (flush) begin
         req_q <= 1'b0;
      end else if (ev_xoff) begin
         req_q  <= 1'b1;
         code_q <= XOFF_CHAR;
      end else if (ev_xon) begin
         req_q  <= 1'b1;
         code_q <= XON_CHAR;
      end else if (ack) begin
         req_q <= 1'b0;
      end
   end

   initial begin
      assert (XOFF_CHAR != XON_CHAR) else $error("flow characters must differ");
   end

   assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> (code_q == XOFF_CHAR || code_q == XON_CHAR));

   assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_q && !ack && !flush |=> req_q);

   assert_code_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_q && !flush && !ev_xoff && !ev_xon |=> $stable(code_q));

   assert_xon_replace_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_xon && !flush |=> req_q && (code_q == XON_CHAR));

endmodule

// File: rtl/rx_flow_trigger.sv
module rx_flow_trigger
   import flow_ctl_pkg::*;
#(
   parameter int                FIFO_DEPTH  = 128,
   parameter int                FIELD_W     = 4,
   parameter int                SCALE_SH    = 3,
   parameter int                CHAR_W      = 8,
   parameter logic [CHAR_W-1:0] XOFF_CHAR   = FC_XOFF_DEFAULT,
   parameter logic [CHAR_W-1:0] XON_CHAR    = FC_XON_DEFAULT,
   parameter bit                HW_PRIORITY = 1'b1,
   localparam int               LVL_W       = $clog2(FIFO_DEPTH + 1),
   localparam int               CFG_W       = 2 * FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              hw_flow_en,
   input  logic              sw_flow_en,
   input  logic [LVL_W-1:0]  fifo_level,
   output logic              rts_o,
   output logic              xchar_req,
   output logic [CHAR_W-1:0] xchar_code,
   input  logic              xchar_ack
);

   logic [LVL_W-1:0] halt_thr;
   logic [LVL_W-1:0] resume_thr;
   fc_mode_e         mode_q;
   logic             mode_chg;
   logic             halted_q;
   logic             ev_halt;
   logic             ev_resume;
   logic             sw_active;

   initial begin
      assert (((2 ** FIELD_W) - 1) * (2 ** SCALE_SH) <= FIFO_DEPTH)
         else $error("largest threshold exceeds the FIFO depth");
      assert (FIFO_DEPTH > 1) else $error("FIFO depth too small");
   end

   flow_thr_reg #(
      .FIELD_W  (FIELD_W),
      .SCALE_SH (SCALE_SH),
      .LVL_W    (LVL_W)
   ) i_thr (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we),
      .wr_data    (cfg_wdata),
      .halt_thr   (halt_thr),
      .resume_thr (resume_thr)
   );

   flow_mode_state #(
      .LVL_W       (LVL_W),
      .HW_PRIORITY (HW_PRIORITY)
   ) i_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .hw_en      (hw_flow_en),
      .sw_en      (sw_flow_en),
      .level      (fifo_level),
      .halt_thr   (halt_thr),
      .resume_thr (resume_thr),
      .mode_q     (mode_q),
      .mode_chg   (mode_chg),
      .halted_q   (halted_q),
      .ev_halt    (ev_halt),
      .ev_resume  (ev_resume)
   );

   assign sw_active = (mode_q == FC_SW);

   flow_char_queue #(
      .CHAR_W    (CHAR_W),
      .XOFF_CHAR (XOFF_CHAR),
      .XON_CHAR  (XON_CHAR)
   ) i_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (mode_chg),
      .ev_xoff (ev_halt && sw_active),
      .ev_xon  (ev_resume && sw_active),
      .ack     (xchar_ack),
      .req_q   (xchar_req),
      .code_q  (xchar_code)
   );

   assign rts_o = halted_q && (mode_q == FC_HW);

   assert_rts_needs_hw_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rts_o |-> $past(hw_flow_en));

   assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_flow_en && !sw_flow_en) |=> (!rts_o && !xchar_req));

   assert_level_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_level <= LVL_W'(FIFO_DEPTH));

endmodule

// File: tb/test_rx_flow_trigger.sv
`timescale 1ns/1ps
module test_rx_flow_trigger;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       hw_flow_en = 1'b0;
   logic       sw_flow_en = 1'b0;
   logic [7:0] fifo_level = '0;
   logic       rts_o;
   logic       xchar_req;
   logic [7:0] xchar_code;
   logic       xchar_ack = 1'b0;

   int compared = 0;
   int mismatched = 0;

   // reference model state
   int md = 0;
   bit mh = 0;
   bit mreq = 0;
   logic [7:0] mcode = '0;
   int mhf = 0;
   int mrf = 0;

   always #10 clk = ~clk;

   rx_flow_trigger i_rx_flow_trigger (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .hw_flow_en (hw_flow_en),
      .sw_flow_en (sw_flow_en),
      .fifo_level (fifo_level),
      .rts_o      (rts_o),
      .xchar_req  (xchar_req),
      .xchar_code (xchar_code),
      .xchar_ack  (xchar_ack)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string tag, input string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int eff_mode(input bit h, input bit s);
      return h ? 1 : (s ? 2 : 0);
   endfunction

   task automatic cyc(input int lvl, input bit ack, input bit h, input bit s,
                      input bit we, input logic [7:0] d, input string tag);
      int  nm;
      bit  ev_h;
      bit  ev_r;
      fifo_level = 8'(lvl);
      xchar_ack  = ack;
      hw_flow_en = h;
      sw_flow_en = s;
      cfg_we     = we;
      cfg_wdata  = d;
      @(posedge clk);
      nm = eff_mode(h, s);
      if (nm != md) begin
         mh   = 0;
         mreq = 0;
      end else begin
         ev_h = (md != 0) && !mh && (lvl >= 8 * mhf);
         ev_r = mh && (lvl <= 8 * mrf);
         if (ev_h)      mh = 1;
         else if (ev_r) mh = 0;
         if (md == 2 && ev_h) begin
            mreq = 1; mcode = 8'h13;
         end else if (md == 2 && ev_r) begin
            mreq = 1; mcode = 8'h11;
         end else if (ack) begin
            mreq = 0;
         end
      end
      md = nm;
      if (we) begin
         mrf = int'(d[7:4]);
         mhf = int'(d[3:0]);
      end
      @(negedge clk);
      chk(32'(rts_o), 32'(md == 1 && mh), tag, "rts");
      chk(32'(xchar_req), 32'(mreq), tag, "req");
      if (mreq) chk(32'(xchar_code), 32'(mcode), tag, "code");
      cfg_we = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: outputs idle during reset
      chk(32'(rts_o), 0, "R1", "rts in reset");
      chk(32'(xchar_req), 0, "R1", "req in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(32'(rts_o), 0, "R1", "rts after reset");

      // R1: register reset to 0 gives halt and resume thresholds of 0
      cyc(0, 0, 1, 0, 0, 8'h00, "R1");
      chk(32'(rts_o), 0, "R1", "mode edge");
      cyc(0, 0, 1, 0, 0, 8'h00, "R1");
      chk(32'(rts_o), 1, "R1", "halt at zero");
      cyc(0, 0, 1, 0, 0, 8'h00, "R1");
      chk(32'(rts_o), 0, "R1", "resume at zero");

      // R12: write timing
      cyc(0, 0, 0, 0, 1, 8'h26, "R12");
      cyc(40, 0, 1, 0, 0, 8'h00, "R12");
      cyc(40, 0, 1, 0, 1, 8'h25, "R12");
      chk(32'(rts_o), 0, "R12", "old threshold on write edge");
      cyc(40, 0, 1, 0, 0, 8'h00, "R12");
      chk(32'(rts_o), 1, "R12", "new threshold next edge");

      // R6 R7 R8 R9: software characters
      cyc(0, 0, 0, 0, 1, 8'h2A, "R8");
      cyc(0, 0, 0, 1, 0, 8'h00, "R8");
      cyc(80, 0, 0, 1, 0, 8'h00, "R6");
      chk(32'(xchar_code), 32'h13, "R6", "xoff code");
      cyc(60, 0, 0, 1, 0, 8'h00, "R8");
      cyc(60, 0, 0, 1, 0, 8'h00, "R8");
      chk(32'(xchar_req), 1, "R8", "held without ack");
      cyc(16, 0, 0, 1, 0, 8'h00, "R9");
      chk(32'(xchar_code), 32'h11, "R9", "xon replaces xoff");
      cyc(16, 1, 0, 1, 0, 8'h00, "R8");
      chk(32'(xchar_req), 0, "R8", "cleared by ack");
      cyc(16, 1, 0, 1, 0, 8'h00, "R7");

      // R11 R10: mode changes and priority
      cyc(96, 0, 0, 1, 0, 8'h00, "R6");
      cyc(96, 0, 1, 0, 0, 8'h00, "R11");
      chk(32'(xchar_req), 0, "R11", "pending dropped");
      chk(32'(rts_o), 0, "R11", "halted cleared");
      cyc(96, 0, 1, 0, 0, 8'h00, "R5");
      cyc(96, 0, 1, 1, 0, 8'h00, "R10");
      chk(32'(rts_o), 1, "R10", "hardware has priority");
      cyc(96, 0, 0, 0, 0, 8'h00, "R10");
      cyc(120, 0, 0, 0, 0, 8'h00, "R10");
      cyc(120, 1, 0, 0, 0, 8'h00, "R10");

      // R2 R3 R4 R5 R6 R7: sweep every threshold pair in both modes
      for (int m = 1; m <= 2; m++) begin
         for (int hv = 0; hv < 16; hv++) begin
            for (int rv = 0; rv < 16; rv++) begin
               cyc(0, 0, 0, 0, 1, {4'(rv), 4'(hv)}, "R2 R3 sweep");
               cyc(0, 0, m == 1, m == 2, 0, 8'h00, "R11 sweep");
               for (int l = 0; l <= 128; l += 4)
                  cyc(l, ((l / 4) % 3) == 0, m == 1, m == 2, 0, 8'h00,
                      "R2 R4 R5 R6 sweep");
               for (int l = 128; l >= 0; l -= 4)
                  cyc(l, ((l / 4) % 3) == 1, m == 1, m == 2, 0, 8'h00,
                      "R3 R4 R5 R7 sweep");
            end
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule